// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether an arriving frame is meant for this station. It watches a byte-wide stream marked by a valid strobe and a start-of-frame strobe. It takes the first six bytes as the destination address and updates a reflected CRC-32 on each byte as it arrives. In the cycle after the sixth byte it raises a one-cycle decision. The decision carries an accept/reject bit and a reason code that names the rule that settled the outcome.

Software sets up the filter through a write-only register port. The port holds a configuration word with three flag bits, three 16-bit station address words and a table of 16-bit multicast hash words. The rules are tried in a fixed priority. First the receive enable gates everything. Then the checks run in this order: promiscuous mode, exact station match, broadcast, and finally the hash bin selected by the six top bits of the CRC. Frame storage, checksums and padding belong to other blocks.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, dec_valid and dec_accept are low. Every register is zero, so the first frame gets a reject with reason 1 (disabled).
- R2: A decision is a single-cycle dec_valid pulse. It is visible in the cycle after the clock edge that captured the sixth valid byte. Bytes after the sixth byte produce no further decision.
- R3: If config bit 0 (receive enable) is clear, the frame is rejected with reason 1, whatever the other bits and the address are.
- R4: With receive enable set and config bit 6 (promiscuous) set, every frame is accepted with reason 2. This takes precedence over a station match.
- R5: Station word 0 (address 1) holds destination byte 0 in bits 15:8 and byte 1 in bits 7:0. Word 1 (address 2) holds bytes 2 and 3, and word 2 (address 3) holds bytes 4 and 5. When all six bytes match, the frame is accepted with reason 3.
- R6: A destination of six 0xFF bytes that did not match the station address is accepted with reason 4. A station address of all ones reports reason 3 instead.
- R7: If config bit 11 (hash enable) is set and no earlier rule matched, an index is formed from CRC bits 31:26. The CRC uses polynomial 0xEDB88320, starts at 0xFFFFFFFF, processes each byte LSB first over the six destination bytes, and has no final inversion. The index selects hash word (index>>4) at address 4+(index>>4), bit (index&15). If that bit is 1, the result is accept with reason 5; if it is 0, reject with reason 6.
- R8: With hash disabled and no rule matched, the frame is rejected with reason 0. dec_accept is 1 exactly when the reason is 2, 3, 4 or 5.
- R9: A start strobe (rx_sof with rx_valid) makes its byte destination byte 0 and discards any partial address. Valid bytes with no frame in progress are ignored.
- R10: A frame that ends before its sixth byte produces no decision.
- R11: Cycles with rx_valid low do not advance the byte count, so gaps inside the address do not change the decision.
- R12: Register address 0 is the configuration word. Station and hash words take bits 15:0 of the write data and ignore the upper bits. A write takes effect for frames decided after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW (3) | Register write address |
| cfg_wdata | input | DATA_W (32) | Register write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame, qualified by rx_valid |
| rx_data | input | 8 | Receive byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted when dec_valid is high |
| dec_reason | output | 3 | Rule that settled the decision |

## Verification
The bench checks the priority chain at its edges:
- Promiscuous mode and a station match set together; if the order were swapped, the reason code would be 3 instead of 2.
- Receive enable cleared while every other rule would accept; a wrongly ordered gate would accept the frame.
- A station address of all ones used with a broadcast frame.

Hash bins are chosen from an independently computed CRC, once with only that bit set and once with every other bit set. A wrong bit order, a missing initial value or a swapped word order would therefore pick the wrong bin. Stream corner cases include a restart in the middle of the address, frames cut short at five bytes, beats with no frame in progress, trailing bytes and gapped beats. A counter that does not reset on a start strobe, or that counts idle cycles, would give no decision, two decisions or a decision one cycle early.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;

   localparam int          DA_BYTES   = 6;
   localparam int          DA_W       = DA_BYTES * 8;
   localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
   localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;

   typedef enum logic [2:0] {
      VD_NO_MATCH  = 3'd0,
      VD_DISABLED  = 3'd1,
      VD_PROMISC   = 3'd2,
      VD_STATION   = 3'd3,
      VD_BCAST     = 3'd4,
      VD_HASH_HIT  = 3'd5,
      VD_HASH_MISS = 3'd6
   } verdict_e;

   // one byte of the reflected CRC, least significant bit first
   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         r = (r >> 1) ^ (((r[0] ^ d[i]) != 1'b0) ? CRC_POLY_R : 32'h0);
      end
      return r;
   endfunction

endpackage

// File: rtl/rx_da_filter_regs.sv
module rx_da_filter_regs #(
   parameter int DATA_W      = 32,
   parameter int HASH_WORDS  = 4,
   parameter int RXEN_BIT    = 0,
   parameter int PROMISC_BIT = 6,
   parameter int HASHEN_BIT  = 11,
   parameter int REG_AW      = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [REG_AW-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic                     rx_en,
   output logic                     promisc,
   output logic                     hash_en,
   output logic [47:0]              station,
   output logic [HASH_WORDS*16-1:0] hash_bits
);
   localparam int STA_BASE  = 1;
   localparam int STA_WORDS = 3;
   localparam int HASH_BASE = STA_BASE + STA_WORDS;
   localparam int NUM_REGS  = HASH_BASE + HASH_WORDS;

   logic [NUM_REGS-1:0] sel;
   logic [15:0]         sta_q  [STA_WORDS];
   logic [15:0]         hash_q [HASH_WORDS];
   logic                unused_wdata;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
      assign sel[r] = wr_en && (wr_addr == REG_AW'(r));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en   <= 1'b0;
         promisc <= 1'b0;
         hash_en <= 1'b0;
         for (int s = 0; s < STA_WORDS; s++) sta_q[s] <= '0;
         for (int h = 0; h < HASH_WORDS; h++) hash_q[h] <= '0;
      end else begin
         if (sel[0]) begin
            rx_en   <= wr_data[RXEN_BIT];
            promisc <= wr_data[PROMISC_BIT];
            hash_en <= wr_data[HASHEN_BIT];
         end
         for (int s = 0; s < STA_WORDS; s++)
            if (sel[STA_BASE+s]) sta_q[s] <= wr_data[15:0];
         for (int h = 0; h < HASH_WORDS; h++)
            if (sel[HASH_BASE+h]) hash_q[h] <= wr_data[15:0];
      end
   end

   // word 0 carries destination byte 0 in its high half
   assign station = {sta_q[0], sta_q[1], sta_q[2]};

   for (genvar h = 0; h < HASH_WORDS; h++) begin : g_hash_flat
      assign hash_bits[16*h +: 16] = hash_q[h];
   end

   assign unused_wdata = ^wr_data;

endmodule

// File: rtl/rx_da_filter_capture.sv
module rx_da_filter_capture
   import rx_da_filter_pkg::*;
#(
   parameter int KEY_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat_valid,
   input  logic             beat_sof,
   input  logic [7:0]       beat_data,
   output logic             fire,
   output logic [DA_W-1:0]  da_next,
   output logic [KEY_W-1:0] key_next
);
   localparam int CNT_W = $clog2(DA_BYTES + 1);

   logic [CNT_W-1:0] cnt_q, cnt_next;
   logic             active_q;
   logic             take;
   logic [DA_W-1:0]  da_q;
   logic [31:0]      crc_q, crc_next;

   always_comb begin
      take     = beat_valid && (beat_sof || active_q);
      cnt_next = beat_sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
      da_next  = beat_sof ? {{(DA_W-8){1'b0}}, beat_data} : {da_q[DA_W-9:0], beat_data};
      crc_next = crc_step(beat_sof ? CRC_SEED : crc_q, beat_data);
      fire     = take && (cnt_next == CNT_W'(DA_BYTES));
      key_next = crc_next[31 -: KEY_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
         da_q     <= '0;
         crc_q    <= CRC_SEED;
      end else if (take) begin
         cnt_q    <= cnt_next;
         active_q <= !fire;
         da_q     <= da_next;
         crc_q    <= crc_next;
      end
   end

endmodule

// File: rtl/rx_da_filter_decide.sv
module rx_da_filter_decide
   import rx_da_filter_pkg::*;
#(
   parameter int HASH_WORDS = 4,
   parameter bit HASH_IMPL  = 1'b1,
   parameter int KEY_W      = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fire,
   input  logic [DA_W-1:0]          da,
   input  logic [KEY_W-1:0]         key,
   input  logic                     rx_en,
   input  logic                     promisc,
   input  logic                     hash_en,
   input  logic [DA_W-1:0]          station,
   input  logic [HASH_WORDS*16-1:0] hash_bits,
   output logic                     dec_valid,
   output logic                     dec_accept,
   output logic [2:0]               dec_reason
);
   logic     hash_hit;
   logic     hash_live;
   verdict_e verdict;
   logic     accept;

   if (HASH_IMPL) begin : g_hash
      assign hash_hit  = hash_bits[key];
      assign hash_live = hash_en;
   end else begin : g_no_hash
      logic unused_hash;
      assign unused_hash = ^{key, hash_bits, hash_en};
      assign hash_hit    = 1'b0;
      assign hash_live   = 1'b0;
   end

   always_comb begin
      if (!rx_en)               verdict = VD_DISABLED;
      else if (promisc)         verdict = VD_PROMISC;
      else if (da == station)   verdict = VD_STATION;
      else if (&da)             verdict = VD_BCAST;
      else if (hash_live)       verdict = hash_hit ? VD_HASH_HIT : VD_HASH_MISS;
      else                      verdict = VD_NO_MATCH;
      accept = (verdict == VD_PROMISC) || (verdict == VD_STATION) ||
               (verdict == VD_BCAST)   || (verdict == VD_HASH_HIT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_reason <= VD_NO_MATCH;
      end else begin
         dec_valid  <= fire;
         dec_accept <= fire && accept;
         dec_reason <= fire ? verdict : VD_NO_MATCH;
      end
   end

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
   import rx_da_filter_pkg::*;
#(
   parameter  int DATA_W      = 32,
   parameter  int HASH_WORDS  = 4,
   parameter  int RXEN_BIT    = 0,
   parameter  int PROMISC_BIT = 6,
   parameter  int HASHEN_BIT  = 11,
   parameter  bit HASH_IMPL   = 1'b1,
   localparam int NUM_REGS    = 4 + HASH_WORDS,
   localparam int REG_AW      = $clog2(NUM_REGS),
   localparam int KEY_W       = $clog2(HASH_WORDS * 16)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [7:0]        rx_data,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [2:0]        dec_reason
);
   if ((1 << KEY_W) != HASH_WORDS * 16 || KEY_W > 32) begin : g_bad_hash
      $error("rx_da_filter: HASH_WORDS must be a power of two");
   end
   if (DATA_W < 16 || RXEN_BIT >= DATA_W || PROMISC_BIT >= DATA_W || HASHEN_BIT >= DATA_W) begin : g_bad_cfg
      $error("rx_da_filter: configuration bits must fit in DATA_W >= 16");
   end

   logic                     rxen_w, prom_w, hashen_w;
   logic [DA_W-1:0]          station_w;
   logic [HASH_WORDS*16-1:0] hash_w;
   logic                     fire_w;
   logic [DA_W-1:0]          da_w;
   logic [KEY_W-1:0]         key_w;

   rx_da_filter_regs #(
      .DATA_W(DATA_W), .HASH_WORDS(HASH_WORDS), .RXEN_BIT(RXEN_BIT),
      .PROMISC_BIT(PROMISC_BIT), .HASHEN_BIT(HASHEN_BIT), .REG_AW(REG_AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
      .rx_en(rxen_w), .promisc(prom_w), .hash_en(hashen_w),
      .station(station_w), .hash_bits(hash_w)
   );

   rx_da_filter_capture #(.KEY_W(KEY_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .beat_valid(rx_valid), .beat_sof(rx_sof),
      .beat_data(rx_data), .fire(fire_w), .da_next(da_w), .key_next(key_w)
   );

   rx_da_filter_decide #(
      .HASH_WORDS(HASH_WORDS), .HASH_IMPL(HASH_IMPL), .KEY_W(KEY_W)
   ) u_decide (
      .clk(clk), .rst_n(rst_n), .fire(fire_w), .da(da_w), .key(key_w),
      .rx_en(rxen_w), .promisc(prom_w), .hash_en(hashen_w),
      .station(station_w), .hash_bits(hash_w),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
   );

endmodule

// File: rtl/rx_da_filter_chk.sv
module rx_da_filter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_valid,
   input logic       dec_valid,
   input logic       dec_accept,
   input logic [2:0] dec_reason,
   input logic       flag_rxen,
   input logic       flag_prom
);
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   a_r10_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(rx_valid));

   a_r3_disabled_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !$past(flag_rxen)) |-> (!dec_accept && dec_reason == 3'd1));

   a_r4_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(flag_rxen && flag_prom)) |-> (dec_accept && dec_reason == 3'd2));

   a_r8_accept_matches_reason: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (dec_accept == (dec_reason >= 3'd2 && dec_reason <= 3'd5)));

   a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_accept);
endmodule

bind rx_da_filter rx_da_filter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
   .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason),
   .flag_rxen(rxen_w), .flag_prom(prom_w)
);

// File: tb/rx_da_filter_tb_top.sv
module rx_da_filter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] RS_NONE = 3'd0, RS_OFF = 3'd1, RS_PROM = 3'd2, RS_STA = 3'd3,
                          RS_BC = 3'd4, RS_HHIT = 3'd5, RS_HMISS = 3'd6;
   localparam logic [31:0] C_EN = 32'h1, C_PROM = 32'h40, C_HASH = 32'h800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        rx_valid = 1'b0;
   logic        rx_sof = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        dec_valid, dec_accept;
   logic [2:0]  dec_reason;

   int n_checks = 0, n_errors = 0, cyc = 0;
   int dec_cnt = 0, dec_cyc = 0;
   logic       s_acc;
   logic [2:0] s_rsn;
   bit         done = 1'b0;

   // model state
   logic [31:0] m_cfg = '0;
   logic [47:0] m_sta = '0;
   logic [63:0] m_hash = '0;

   rx_da_filter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (dec_valid) begin
      dec_cnt++; dec_cyc = cyc; s_acc = dec_accept; s_rsn = dec_reason;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input logic [47:0] da);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int b = 0; b < 6; b++)
         for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = c[0] ^ da[40 - 8*b + k];
            c = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB8_8320;
         end
      return c;
   endfunction

   function automatic logic [2:0] model(input logic [47:0] da);
      logic [5:0] idx;
      idx = ref_crc(da)[31:26];
      if (!m_cfg[0]) return RS_OFF;
      if (m_cfg[6]) return RS_PROM;
      if (da == m_sta) return RS_STA;
      if (da == 48'hFFFF_FFFF_FFFF) return RS_BC;
      if (m_cfg[11]) return m_hash[idx] ? RS_HHIT : RS_HMISS;
      return RS_NONE;
   endfunction

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (a == 0) m_cfg = d;
      else if (a <= 3) m_sta[47 - 16*(a-1) -: 16] = d[15:0];
      else m_hash[16*(a-4) +: 16] = d[15:0];
   endtask

   task automatic beat(input logic s, input logic [7:0] d, output int c);
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = s; rx_data = d; c = cyc;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         rx_valid = 1'b0; rx_sof = 1'b0;
      end
   endtask

   // send n bytes: first six from da (byte 0 first), the rest filler
   task automatic send(input logic [47:0] da, input int n, input bit sof, input bit gap, output int c6);
      int c;
      c6 = -1;
      for (int i = 0; i < n; i++) begin
         beat(sof && i == 0, (i < 6) ? da[47 - 8*i -: 8] : 8'hA5, c);
         if (i == 5) c6 = c;
         if (gap) idle(1);
      end
      idle(4);
   endtask

   task automatic frame(input string tag, input logic [47:0] da, input int n, input bit gap);
      int base, c6;
      logic [2:0] exp;
      base = dec_cnt;
      exp = model(da);
      send(da, n, 1'b1, gap, c6);
      check(dec_cnt - base == 1, {tag, " one decision (R2)"}, dec_cnt - base, 1);
      check(dec_cyc == c6 + 1, {tag, " latency (R2)"}, dec_cyc, c6 + 1);
      check(s_rsn == exp, {tag, " reason"}, s_rsn, exp);
      check(s_acc == (exp >= RS_PROM && exp <= RS_HHIT), {tag, " accept"}, s_acc,
            (exp >= RS_PROM && exp <= RS_HHIT));
   endtask

   localparam logic [47:0] STA = 48'h0011_2233_4455;
   localparam logic [47:0] MC  = 48'h0100_5E00_0001;
   localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

   task automatic t_reset;
      check(dec_valid == 1'b0, "R1 dec_valid after reset", dec_valid, 0);
      check(dec_accept == 1'b0, "R1 dec_accept after reset", dec_accept, 0);
      frame("R1 frame after reset", STA, 6, 1'b0);
      check(s_rsn == RS_OFF, "R1 disabled reason", s_rsn, RS_OFF);
   endtask

   task automatic t_disabled;
      wr(1, 32'h0011); wr(2, 32'h2233); wr(3, 32'h4455);
      wr(0, C_PROM | C_HASH);
      frame("R3 disabled station", STA, 6, 1'b0);
      frame("R3 disabled bcast", BC, 6, 1'b0);
   endtask

   task automatic t_promisc;
      wr(0, C_EN | C_PROM);
      frame("R4 promisc random", 48'h1234_5678_9ABC, 6, 1'b0);
      frame("R4 promisc over station", STA, 6, 1'b0);
      check(s_rsn == RS_PROM, "R4 precedence", s_rsn, RS_PROM);
   endtask

   task automatic t_station;
      wr(0, C_EN);
      wr(1, 32'hABCD_0011);   // upper bits ignored (R12)
      frame("R5 R12 station match", STA, 6, 1'b0);
      check(s_rsn == RS_STA, "R5 station reason", s_rsn, RS_STA);
      frame("R8 near miss last byte", STA ^ 48'h1, 6, 1'b0);
      check(s_rsn == RS_NONE, "R8 no match reason", s_rsn, RS_NONE);
      frame("R8 near miss first byte", STA ^ 48'h8000_0000_0000, 6, 1'b0);
   endtask

   task automatic t_bcast;
      frame("R6 broadcast", BC, 6, 1'b0);
      check(s_rsn == RS_BC, "R6 bcast reason", s_rsn, RS_BC);
      wr(1, 32'hFFFF); wr(2, 32'hFFFF); wr(3, 32'hFFFF);
      frame("R6 station all ones", BC, 6, 1'b0);
      check(s_rsn == RS_STA, "R6 station before bcast", s_rsn, RS_STA);
      wr(1, 32'h0011); wr(2, 32'h2233); wr(3, 32'h4455);
   endtask

   task automatic t_hash;
      logic [5:0] idx;
      idx = ref_crc(MC)[31:26];
      wr(0, C_EN | C_HASH);
      frame("R7 hash empty", MC, 6, 1'b0);
      check(s_rsn == RS_HMISS, "R7 miss reason", s_rsn, RS_HMISS);
      wr(4 + int'(idx >> 4), 32'(1) << idx[3:0]);
      frame("R7 hash bit set", MC, 6, 1'b0);
      check(s_rsn == RS_HHIT, "R7 hit reason", s_rsn, RS_HHIT);
      for (int w = 0; w < 4; w++)
         wr(4 + w, (w == int'(idx >> 4)) ? ~(32'(1) << idx[3:0]) : 32'hFFFF);
      frame("R7 all but own bin", MC, 6, 1'b0);
      for (int w = 0; w < 4; w++) wr(4 + w, 32'h0);
      wr(0, C_EN);
   endtask

   task automatic t_stream;
      int base, c, c6;
      // restart mid-address (R9)
      beat(1'b1, 8'h77, c); beat(1'b0, 8'h66, c); beat(1'b0, 8'h55, c);
      frame("R9 restart", STA, 6, 1'b0);
      check(s_rsn == RS_STA, "R9 restart reason", s_rsn, RS_STA);
      // beats with no frame open (R9)
      base = dec_cnt;
      send(STA, 6, 1'b0, 1'b0, c6);
      check(dec_cnt == base, "R9 beats without start", dec_cnt - base, 0);
      // short frame (R10)
      base = dec_cnt;
      send(STA, 5, 1'b1, 1'b0, c6);
      check(dec_cnt == base, "R10 five bytes", dec_cnt - base, 0);
      // trailing bytes (R2)
      frame("R2 trailing bytes", STA, 9, 1'b0);
      // gapped beats (R11)
      frame("R11 gapped", STA, 6, 1'b1);
      check(s_rsn == RS_STA, "R11 gapped reason", s_rsn, RS_STA);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_promisc();
      t_station();
      t_bcast();
      t_hash();
      t_stream();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule